// File: doc/BRIEF.md
# PCI Host Bridge Control Registers

This block is the register face of an on-chip PCI host controller. A CPU reaches it over a plain 32-bit register bus with a request/ready handshake. Behind that bus sit a 256-byte copy of the host's own configuration header, an address register and a data port for indirect configuration cycles, and two base registers that place the memory and I/O windows in the CPU address map.

An access to the data port is turned into one 32-bit configuration read or write on a request/acknowledge interface, addressed by whatever the address register holds. The register bus is held not-ready until the configuration side acknowledges. If no acknowledge comes, a timeout completes the access anyway, and a read then returns all ones. The block also compares a CPU address against the I/O base and reports a hit with the offset into the 256 KiB window. It latches interrupt levels reported per device and drives one of four interrupt outputs per slot, where the slot is the device/function number with its low three bits dropped.

Top module: `pcih_ctl`

## Requirements
- R1: Byte offsets 0x000 to 0x0FC address 64 words of local header storage; a 32-bit write to any of them is read back unchanged.
- R2: After reset the header word at offset 0x004 reads 0x02900080 (command bit 7 wait cycles; status bits 4 capability list, 7 fast back-to-back, 9 medium select timing); every other header word reads zero.
- R3: Offset 0x1C0 is the configuration address register; it stores all 32 written bits and resets to zero.
- R4: Offset 0x1C4 is the memory base register; it keeps only bits 31:24 and bit 0 of a write, and all other bits read zero.
- R5: Offset 0x1C8 is the I/O base register; it resets to 0xFE240000 and stores a write masked to bits 31:18 and bit 0, but only when the written bits 31:18 differ from the stored ones; otherwise the whole write, bit 0 included, is dropped.
- R6: `io_hit` is high exactly when `cpu_addr[31:18]` equals the I/O base bits 31:18, and `io_off` then equals `cpu_addr` minus that base.
- R7: A write to offset 0x220 raises `cfg_req` with `cfg_wr` high, the address register value on `cfg_addr` and the written data on `cfg_wdata`.
- R8: A read of offset 0x220 raises `cfg_req` with `cfg_wr` low; `reg_rdy` stays low until `cfg_ack`, and the read returns `cfg_rdata` of the acknowledging cycle; `cfg_addr` is stable while the request waits.
- R9: If no acknowledge arrives within `TMO_CYC` cycles, the data port access completes, `cfg_req` drops, and a read returns 0xFFFFFFFF.
- R10: An access whose `reg_size` is not 2 (32-bit), whose offset is not 4-byte aligned, or whose offset lies outside the decoded registers (the gaps, or at or above 0x224) completes at once, reads zero, changes nothing and raises no configuration request.
- R11: An interrupt report with `irq_devfn[7:3]` below 4 sets `irq_out[irq_devfn[4:3]]` to `irq_lvl` from the next cycle; reports for higher slots are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_req | input | 1 | Register access request, held until `reg_rdy` |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 12 | Byte offset |
| reg_size | input | 2 | Access size code, 2 = 32-bit |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid with `reg_rdy` |
| reg_rdy | output | 1 | Access completes at this clock edge |
| cfg_req | output | 1 | Configuration cycle request |
| cfg_wr | output | 1 | Configuration write when high |
| cfg_addr | output | 32 | Configuration address |
| cfg_wdata | output | 32 | Configuration write data |
| cfg_ack | input | 1 | Configuration cycle done |
| cfg_rdata | input | 32 | Configuration read data |
| cpu_addr | input | 32 | CPU address to decode |
| io_hit | output | 1 | `cpu_addr` is in the I/O window |
| io_off | output | 18 | Offset into the I/O window |
| irq_vld | input | 1 | Interrupt level report valid |
| irq_devfn | input | 8 | Reporting device/function number |
| irq_lvl | input | 1 | Reported interrupt level |
| irq_out | output | 4 | Interrupt lines, one per slot |

## Verification
The I/O window decoder runs every cycle, so a write that relocates the I/O base lands in a cycle where the decoder is judging a live CPU address; the bench keeps `cpu_addr` sweeping just below, at and above the window edges while base writes, both changing and non-changing, complete, and its model switches base in the same cycle as the design. Likewise interrupt reports are injected while a data port access is stalled waiting for acknowledge, and the per-cycle comparison of `irq_out` shows the stall does not delay the interrupt update.

// File: rtl/pcih_ctl.sv
module pcih_ctl #(
  parameter int          TMO_CYC = 256,
  parameter logic [31:0] IOB_RST = 32'hFE24_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_req,
  input  logic        reg_wr,
  input  logic [11:0] reg_addr,
  input  logic [1:0]  reg_size,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        reg_rdy,
  output logic        cfg_req,
  output logic        cfg_wr,
  output logic [31:0] cfg_addr,
  output logic [31:0] cfg_wdata,
  input  logic        cfg_ack,
  input  logic [31:0] cfg_rdata,
  input  logic [31:0] cpu_addr,
  output logic        io_hit,
  output logic [17:0] io_off,
  input  logic        irq_vld,
  input  logic [7:0]  irq_devfn,
  input  logic        irq_lvl,
  output logic [3:0]  irq_out
);
  localparam int          TW       = $clog2(TMO_CYC + 1);
  localparam int          NWORDS   = 64;
  localparam logic [31:0] MEM_MASK = 32'hFF00_0001;
  localparam logic [31:0] IOB_MASK = 32'hFFFC_0001;
  localparam logic [31:0] HDR1_RST = 32'h0290_0080;

  logic [31:0] hdr [NWORDS];
  logic [31:0] adr_q, mem_base_q, io_base_q;
  logic [TW-1:0] wait_cnt;
  logic [3:0] irq_q;

  logic legal, is_hdr, is_adr, is_mem, is_iob, is_dat;
  logic dp_pend, tmo, dp_done, we;

  assign legal  = reg_size == 2'd2 && reg_addr[1:0] == 2'b00 && reg_addr < 12'h224;
  assign is_hdr = legal && reg_addr[11:8] == 4'h0;
  assign is_adr = legal && reg_addr == 12'h1C0;
  assign is_mem = legal && reg_addr == 12'h1C4;
  assign is_iob = legal && reg_addr == 12'h1C8;
  assign is_dat = legal && reg_addr == 12'h220;

  assign dp_pend = reg_req && is_dat;
  assign tmo     = wait_cnt == TW'(TMO_CYC);
  assign cfg_req = dp_pend && !tmo;
  assign dp_done = (cfg_req && cfg_ack) || (dp_pend && tmo);
  assign reg_rdy = reg_req && (is_dat ? dp_done : 1'b1);
  assign we      = reg_rdy && reg_wr;

  assign cfg_wr    = reg_wr;
  assign cfg_addr  = adr_q;
  assign cfg_wdata = reg_wdata;

  always_comb begin
    reg_rdata = '0;
    if (is_hdr)      reg_rdata = hdr[reg_addr[7:2]];
    else if (is_adr) reg_rdata = adr_q;
    else if (is_mem) reg_rdata = mem_base_q;
    else if (is_iob) reg_rdata = io_base_q;
    else if (is_dat) reg_rdata = tmo ? 32'hFFFF_FFFF : cfg_rdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NWORDS; i++) hdr[i] <= (i == 1) ? HDR1_RST : '0;
    end else if (we && is_hdr) begin
      hdr[reg_addr[7:2]] <= reg_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      adr_q      <= '0;
      mem_base_q <= '0;
      io_base_q  <= IOB_RST & IOB_MASK;
    end else if (we) begin
      if (is_adr) adr_q <= reg_wdata;
      if (is_mem) mem_base_q <= reg_wdata & MEM_MASK;
      if (is_iob && reg_wdata[31:18] != io_base_q[31:18]) io_base_q <= reg_wdata & IOB_MASK;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !dp_pend || reg_rdy) wait_cnt <= '0;
    else                               wait_cnt <= wait_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= '0;
    else if (irq_vld && irq_devfn[7:5] == 3'b000) irq_q[irq_devfn[4:3]] <= irq_lvl;
  end
  assign irq_out = irq_q;

  assign io_hit = cpu_addr[31:18] == io_base_q[31:18];
  assign io_off = cpu_addr[17:0];
endmodule

// File: rtl/pcih_ctl_chk.sv
module pcih_ctl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_req,
  input logic        reg_wr,
  input logic [11:0] reg_addr,
  input logic [1:0]  reg_size,
  input logic [31:0] reg_wdata,
  input logic [31:0] reg_rdata,
  input logic        reg_rdy,
  input logic        cfg_req,
  input logic        cfg_ack,
  input logic [31:0] cfg_addr,
  input logic [31:0] io_base_q
);
  assert_mem_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req && !reg_wr && reg_size == 2'd2 && reg_addr == 12'h1C4) |-> (reg_rdata & ~32'hFF00_0001) == 32'h0);

  assert_iob_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdy && reg_wr && reg_size == 2'd2 && reg_addr == 12'h1C8 && reg_wdata[31:18] == io_base_q[31:18])
    |=> $stable(io_base_q));

  assert_cfg_only_port_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req |-> (reg_req && reg_addr == 12'h220 && reg_size == 2'd2));

  assert_cfg_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_req && !cfg_ack) |=> $stable(cfg_addr));

  assert_rdy_needs_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdy |-> reg_req);

  assert_undecoded_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req && reg_size != 2'd2) |-> (reg_rdy && reg_rdata == 32'h0 && !cfg_req));
endmodule

bind pcih_ctl pcih_ctl_chk chk_i (.*);

// File: tb/pcih_ctl_tb_top.sv
module pcih_ctl_tb_top;
  localparam int TMO = 16;

  logic clk = 0, rst_n = 0;
  logic reg_req = 0, reg_wr = 0;
  logic [11:0] reg_addr = '0;
  logic [1:0]  reg_size = 2'd2;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic reg_rdy;
  logic cfg_req, cfg_wr, cfg_ack = 0;
  logic [31:0] cfg_addr, cfg_wdata, cfg_rdata = '0;
  logic [31:0] cpu_addr = '0;
  logic io_hit;
  logic [17:0] io_off;
  logic irq_vld = 0, irq_lvl = 0;
  logic [7:0] irq_devfn = '0;
  logic [3:0] irq_out;

  int checks = 0, errors = 0;
  bit run_mon = 0;
  logic [31:0] m_iob = 32'hFE24_0000;
  logic [3:0]  m_irq = '0;
  int rsp_dly = 0;
  bit rsp_off = 0;
  int rcnt = 0;
  logic [31:0] wlog_a [$];
  logic [31:0] wlog_d [$];
  int cyc = 0;

  always #10 clk = ~clk;

  pcih_ctl #(.TMO_CYC(TMO)) dut_i (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #2;
    if (cfg_req && !rsp_off) begin
      if (rcnt == rsp_dly) begin
        cfg_ack = 1;
        cfg_rdata = cfg_addr ^ 32'h5A5A_0000;
        if (cfg_wr) begin wlog_a.push_back(cfg_addr); wlog_d.push_back(cfg_wdata); end
        rcnt = 0;
      end else begin
        cfg_ack = 0;
        rcnt++;
      end
    end else begin
      cfg_ack = 0;
      rcnt = 0;
    end
  end

  always @(posedge clk) begin
    #3;
    cyc++;
    case (cyc % 6)
      0: cpu_addr = {m_iob[31:18], 18'h0} - 32'd1;
      1: cpu_addr = {m_iob[31:18], 18'h0};
      2: cpu_addr = {m_iob[31:18], 18'h3FFFF};
      3: cpu_addr = {m_iob[31:18], 18'h0} + 32'h4_0000;
      4: cpu_addr = {m_iob[31:18], 18'h0} + ($urandom & 32'h3FFFF);
      default: cpu_addr = $urandom;
    endcase
  end

  always @(negedge clk) begin
    if (run_mon) begin
      logic eh;
      eh = cpu_addr[31:18] == m_iob[31:18];
      chk("R6 hit", {31'b0, io_hit}, {31'b0, eh});
      if (eh) chk("R6 off", {14'b0, io_off}, {14'b0, cpu_addr[17:0] - m_iob[17:0] + {17'b0, m_iob[0]}});
      chk("R11 irq", {28'b0, irq_out}, {28'b0, m_irq});
    end
  end

  task automatic acc(bit wr, logic [11:0] a, logic [1:0] sz, logic [31:0] wd, output logic [31:0] rd, output int ncyc);
    @(negedge clk);
    reg_req = 1; reg_wr = wr; reg_addr = a; reg_size = sz; reg_wdata = wd;
    ncyc = 0;
    forever begin
      #5;
      if (reg_rdy) begin
        rd = reg_rdata;
        @(posedge clk); #1;
        reg_req = 0;
        if (wr && sz == 2'd2 && a == 12'h1C8 && wd[31:18] != m_iob[31:18]) m_iob = wd & 32'hFFFC_0001;
        break;
      end
      ncyc++;
      @(negedge clk);
    end
  endtask

  task automatic wr32(logic [11:0] a, logic [31:0] d);
    logic [31:0] r; int n;
    acc(1, a, 2'd2, d, r, n);
  endtask

  task automatic rd_chk(string req, logic [11:0] a, logic [1:0] sz, logic [31:0] exp);
    logic [31:0] r; int n;
    acc(0, a, sz, 32'h0, r, n);
    chk(req, r, exp);
  endtask

  task automatic irq_rep(logic [7:0] dfn, bit lvl);
    @(negedge clk);
    irq_vld = 1; irq_devfn = dfn; irq_lvl = lvl;
    @(posedge clk); #1;
    irq_vld = 0;
    if (dfn[7:5] == 3'b000) m_irq[dfn[4:3]] = lvl;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] r; int n;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    run_mon = 1;

    rd_chk("R2 hdr word1 reset", 12'h004, 2'd2, 32'h0290_0080);
    rd_chk("R2 hdr word0 reset", 12'h000, 2'd2, 32'h0);
    rd_chk("R2 hdr last reset", 12'h0FC, 2'd2, 32'h0);
    rd_chk("R3 addr reset", 12'h1C0, 2'd2, 32'h0);
    rd_chk("R4 mem reset", 12'h1C4, 2'd2, 32'h0);
    rd_chk("R5 iob reset", 12'h1C8, 2'd2, 32'hFE24_0000);
    chk("R11 irq reset", {28'b0, irq_out}, 32'h0);

    wr32(12'h000, 32'h1122_3344);
    wr32(12'h0FC, 32'hA5A5_5A5A);
    wr32(12'h004, 32'h0000_FFFF);
    rd_chk("R1 hdr 000", 12'h000, 2'd2, 32'h1122_3344);
    rd_chk("R1 hdr 0FC", 12'h0FC, 2'd2, 32'hA5A5_5A5A);
    rd_chk("R1 hdr 004", 12'h004, 2'd2, 32'h0000_FFFF);

    wr32(12'h1C0, 32'hDEAD_BEEF);
    rd_chk("R3 addr all bits", 12'h1C0, 2'd2, 32'hDEAD_BEEF);
    wr32(12'h1C4, 32'hFFFF_FFFF);
    rd_chk("R4 mem mask", 12'h1C4, 2'd2, 32'hFF00_0001);
    wr32(12'h1C4, 32'h12FF_FFFE);
    rd_chk("R4 mem mask 2", 12'h1C4, 2'd2, 32'h1200_0000);

    wr32(12'h1C8, 32'h1234_5677);
    rd_chk("R5 iob relocate", 12'h1C8, 2'd2, 32'h1234_0001);
    repeat (8) @(posedge clk);
    wr32(12'h1C8, 32'h1234_7FFE);
    rd_chk("R5 iob same upper ignored", 12'h1C8, 2'd2, 32'h1234_0001);
    wr32(12'h1C8, 32'h1234_0000);
    rd_chk("R5 iob bit0-only ignored", 12'h1C8, 2'd2, 32'h1234_0001);
    repeat (8) @(posedge clk);
    wr32(12'h1C8, 32'h0004_0000);
    rd_chk("R5 iob relocate low", 12'h1C8, 2'd2, 32'h0004_0000);
    repeat (8) @(posedge clk);

    wr32(12'h1C0, 32'h8000_1004);
    rsp_dly = 2;
    wr32(12'h220, 32'hCAFE_0001);
    chk("R7 one cfg write", wlog_a.size(), 1);
    if (wlog_a.size() > 0) begin
      chk("R7 cfg write addr", wlog_a.pop_front(), 32'h8000_1004);
      chk("R7 cfg write data", wlog_d.pop_front(), 32'hCAFE_0001);
    end

    rsp_dly = 3;
    fork
      acc(0, 12'h220, 2'd2, 32'h0, r, n);
      begin repeat (2) @(posedge clk); irq_rep(8'h08, 1); end
    join
    chk("R8 cfg read data", r, 32'h8000_1004 ^ 32'h5A5A_0000);
    chk("R8 stall cycles", n >= 3, 1);
    chk("R11 slot1 during stall", {28'b0, irq_out}, 32'h2);
    rsp_dly = 0;
    wr32(12'h1C0, 32'h0000_0800);
    rd_chk("R8 cfg read no delay", 12'h220, 2'd2, 32'h0000_0800 ^ 32'h5A5A_0000);

    rsp_off = 1;
    acc(0, 12'h220, 2'd2, 32'h0, r, n);
    chk("R9 timeout read ones", r, 32'hFFFF_FFFF);
    chk("R9 timeout length", n >= TMO, 1);
    acc(1, 12'h220, 2'd2, 32'h1234_5678, r, n);
    chk("R9 timeout write no cfg", wlog_a.size(), 0);
    rsp_off = 0;

    rd_chk("R10 size1 read", 12'h000, 2'd1, 32'h0);
    acc(1, 12'h000, 2'd0, 32'hFFFF_FFFF, r, n);
    rd_chk("R10 size0 write ignored", 12'h000, 2'd2, 32'h1122_3344);
    rd_chk("R10 misaligned read", 12'h002, 2'd2, 32'h0);
    acc(1, 12'h001, 2'd2, 32'hFFFF_FFFF, r, n);
    rd_chk("R10 misaligned write ignored", 12'h000, 2'd2, 32'h1122_3344);
    wr32(12'h100, 32'h7777_7777);
    rd_chk("R10 gap read", 12'h100, 2'd2, 32'h0);
    rd_chk("R10 past end read", 12'h224, 2'd2, 32'h0);
    acc(1, 12'h1C0, 2'd1, 32'h5555_5555, r, n);
    rd_chk("R10 size1 addr write ignored", 12'h1C0, 2'd2, 32'h0000_0800);
    acc(0, 12'h220, 2'd1, 32'h0, r, n);
    chk("R10 port bad size no stall", n, 0);
    chk("R10 port bad size zero", r, 32'h0);

    irq_rep(8'h1B, 1);
    irq_rep(8'h20, 1);
    irq_rep(8'hF8, 1);
    @(negedge clk);
    chk("R11 slot3 set, high slots ignored", {28'b0, irq_out}, 32'hA);
    irq_rep(8'h08, 0);
    irq_rep(8'h00, 1);
    @(negedge clk);
    chk("R11 slot1 clear slot0 set", {28'b0, irq_out}, 32'h9);

    repeat (12) @(posedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule